// File: doc/BRIEF.md
# PCI Hotplug Status Register Bank

This block is the firmware-facing status bank for PCI hot insertion and hot removal across a configurable number of hotplug buses of 32 slots each. For every bus it keeps three 32-bit bitmaps. The first records which slots received a device (inserted). The second records which slots have a pending removal request. The third records which slots may be removed at all (removable). Firmware reaches the bank through a 32-bit register window. A bus-select register picks which bus's bitmaps the window shows.

The platform side reports insertions and removal requests with single-cycle event inputs. Each event raises a one-cycle notification pulse so that firmware can run its handler. Firmware acknowledges a removal by writing the eject register. The bank then emits a single-cycle eject strobe carrying the bus and slot, and the platform tears the device down. Firmware can also fetch a per-slot index value through a two-step handshake: write the slot, then read the value.

A warm-reset request makes the bank sweep all buses and eject every removal still pending, then reload the removable bitmaps. The removable bitmaps are loaded from a per-slot non-hotpluggable mask. A legacy mode keeps the inserted bitmap sticky on reads and pins the bus select to its default value.

Top module: `hp_status_bank`

## Requirements
- R1: After `rst` the bus select reads DEFAULT_BUS (0), the inserted and removal bitmaps of every bus are zero, each removable bitmap equals the inverse of that bus's 32-bit slice of `fixed_mask`, and `notify`, `eject_valid` and `rsp_valid` are low.
- R2: A plug event sets bit `plug_slot` in the inserted bitmap of `plug_bus`. An unplug request sets the bit in the removal bitmap. Either event raises `notify` for exactly one cycle, in the cycle after the event.
- R3: Reading word 0 (byte offset 0x00) returns the selected bus's inserted bitmap and clears it, unless `legacy_mode` is high, in which case the bitmap is kept.
- R4: Word 1 (0x04) reads the removal bitmap, word 3 (0x0C) reads the removable bitmap, and word 2 (0x08) always reads zero.
- R5: Writing word 2 takes the lowest set bit of the write data as a slot. It clears that slot in both the inserted and removal bitmaps of the selected bus, and raises `eject_valid` for one cycle, in the cycle after the write, with that bus and slot. Write data of zero does nothing.
- R6: Writing word 4 (0x10) stores the 32-bit data as bus select, and reading word 4 returns it. In legacy mode the write stores DEFAULT_BUS instead.
- R7: While the bus select is NUM_BUS or above, every read returns zero, and eject and index writes change nothing.
- R8: Writing word 5 (0x14) latches the `idx_table` entry of the selected bus and the slot given by the lowest set data bit. Entry (b,s) is at bits `(b*32+s)*IDX_W` and up. The next read of word 5 returns the value zero-extended and then clears it.
- R9: Every register write first clears the latched index value.
- R10: When an event sets a bit in the same cycle that a read or eject clears it, the set wins.
- R11: A `warm_rst` pulse starts a sweep. The sweep visits buses in ascending order and, within a bus, ejects pending removals lowest slot first, one per cycle, each with an `eject_valid` strobe. It then reloads every removable bitmap from `fixed_mask`. During the sweep, reads return zero and writes are ignored.
- R12: `rsp_valid` is high in the cycle after each read request, with `rsp_rdata`. Address bits 1:0 are ignored, and words 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warm_rst | input | 1 | Pulse that starts the eject sweep |
| legacy_mode | input | 1 | Sticky inserted bitmap, fixed bus select |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte address in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| plug_valid | input | 1 | Device inserted event |
| plug_bus | input | BUS_W | Bus of inserted device |
| plug_slot | input | 5 | Slot of inserted device |
| unplug_valid | input | 1 | Removal request event |
| unplug_bus | input | BUS_W | Bus of removal request |
| unplug_slot | input | 5 | Slot of removal request |
| fixed_mask | input | NUM_BUS*32 | Non-hotpluggable slots, one bit per slot |
| idx_table | input | NUM_BUS*32*IDX_W | Per-slot index values |
| notify | output | 1 | Firmware notification pulse |
| eject_valid | output | 1 | Eject strobe |
| eject_bus | output | BUS_W | Bus to tear down |
| eject_slot | output | 5 | Slot to tear down |

## Verification
A corrupted bitmap bit shows up at the next read of the owning bus, one cycle after the request. A lost read-clear shows as a repeated value on the second read of word 0. A wrong lowest-bit decode shows in the same cycle as a mismatched `eject_slot` or a wrong index value. A sweep that skips a bus or visits slots out of order shows in the sequence of `eject_valid` strobes within a few cycles of `warm_rst`. A missing reload shows as a stale removable bitmap read right after the sweep.

// File: rtl/hp_regbank_pkg.sv
package hp_regbank_pkg;
  localparam int SLOTS  = 32;
  localparam int SLOT_W = 5;
  localparam int DATA_W = 32;

  // word index = byte address bits 4:2
  localparam logic [2:0] WRD_INSERT = 3'd0;
  localparam logic [2:0] WRD_REMOVE = 3'd1;
  localparam logic [2:0] WRD_EJECT  = 3'd2;
  localparam logic [2:0] WRD_RMVBL  = 3'd3;
  localparam logic [2:0] WRD_SELECT = 3'd4;
  localparam logic [2:0] WRD_INDEX  = 3'd5;

  // index of lowest set bit; SLOTS when none is set
  function automatic logic [SLOT_W:0] lowest_set(input logic [SLOTS-1:0] v);
    logic [SLOT_W:0] r;
    r = (SLOT_W+1)'(SLOTS);
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (v[i]) r = (SLOT_W+1)'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/hp_bus_status.sv
module hp_bus_status
  import hp_regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] set_up,
  input  logic [SLOTS-1:0] set_dn,
  input  logic [SLOTS-1:0] clr_up,
  input  logic [SLOTS-1:0] clr_dn,
  input  logic             load_rmv,
  input  logic [SLOTS-1:0] fixed_mask,
  output logic [SLOTS-1:0] up,
  output logic [SLOTS-1:0] dn,
  output logic [SLOTS-1:0] rmv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      up  <= '0;
      dn  <= '0;
      rmv <= ~fixed_mask;
    end else begin
      up <= (up & ~clr_up) | set_up;
      dn <= (dn & ~clr_dn) | set_dn;
      if (load_rmv) rmv <= ~fixed_mask;
    end
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (|set_up) |=> ((up & $past(set_up)) == $past(set_up)));

  assert_dn_set_R2: assert property (@(posedge clk) disable iff (rst)
    (|set_dn) |=> ((dn & $past(set_dn)) == $past(set_dn)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (|(clr_dn & ~set_dn)) |=> ((dn & $past(clr_dn & ~set_dn)) == '0));
endmodule

// File: rtl/hp_sweep.sv
module hp_sweep
  import hp_regbank_pkg::*;
#(
  parameter int NUM_BUS = 4,
  parameter int BUS_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SLOTS-1:0]  dn_bus [NUM_BUS],
  output logic              active,
  output logic              ej_req,
  output logic [BUS_W-1:0]  ej_bus,
  output logic [SLOT_W-1:0] ej_slot,
  output logic              done
);
  logic             active_q;
  logic [BUS_W-1:0] cur_q;
  logic [SLOTS-1:0] cur_dn;
  logic [SLOT_W:0]  low;
  logic             last;

  assign cur_dn  = dn_bus[cur_q];
  assign low     = lowest_set(cur_dn);
  assign last    = (cur_q == BUS_W'(NUM_BUS - 1));
  assign active  = active_q;
  assign ej_req  = active_q && (cur_dn != '0);
  assign ej_bus  = cur_q;
  assign ej_slot = low[SLOT_W-1:0];
  assign done    = active_q && (cur_dn == '0) && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cur_q    <= '0;
    end else if (!active_q) begin
      if (start) begin
        active_q <= 1'b1;
        cur_q    <= '0;
      end
    end else if (cur_dn == '0) begin
      if (last) active_q <= 1'b0;
      else      cur_q    <= cur_q + 1'b1;
    end
  end

  assert_sweep_order_R11: assert property (@(posedge clk) disable iff (rst)
    (active_q && $past(active_q)) |-> (cur_q >= $past(cur_q)));

  assert_sweep_slot_R11: assert property (@(posedge clk) disable iff (rst)
    ej_req |-> cur_dn[ej_slot]);
endmodule

// File: rtl/hp_status_bank.sv
module hp_status_bank
  import hp_regbank_pkg::*;
#(
  parameter int NUM_BUS     = 4,
  parameter int IDX_W       = 14,
  parameter int DEFAULT_BUS = 0,
  localparam int BUS_W      = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          warm_rst,
  input  logic                          legacy_mode,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [4:0]                    req_addr,
  input  logic [31:0]                   req_wdata,
  output logic                          rsp_valid,
  output logic [31:0]                   rsp_rdata,
  input  logic                          plug_valid,
  input  logic [BUS_W-1:0]              plug_bus,
  input  logic [4:0]                    plug_slot,
  input  logic                          unplug_valid,
  input  logic [BUS_W-1:0]              unplug_bus,
  input  logic [4:0]                    unplug_slot,
  input  logic [NUM_BUS*32-1:0]         fixed_mask,
  input  logic [NUM_BUS*32*IDX_W-1:0]   idx_table,
  output logic                          notify,
  output logic                          eject_valid,
  output logic [BUS_W-1:0]              eject_bus,
  output logic [4:0]                    eject_slot
);
  localparam int ENTRIES = NUM_BUS * SLOTS;

  logic [SLOTS-1:0] up_a   [NUM_BUS];
  logic [SLOTS-1:0] dn_a   [NUM_BUS];
  logic [SLOTS-1:0] rmv_a  [NUM_BUS];
  logic [IDX_W-1:0] idx_view [ENTRIES];

  logic [DATA_W-1:0] sel_q;
  logic [IDX_W-1:0]  idx_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_q;
  logic              notify_q;
  logic              ej_v_q;
  logic [BUS_W-1:0]  ej_b_q;
  logic [4:0]        ej_s_q;

  logic [1:0]        unused_addr_lo;
  logic [2:0]        word;
  logic              sweeping, sw_req, sw_done;
  logic [BUS_W-1:0]  sw_bus;
  logic [SLOT_W-1:0] sw_slot;
  logic              acc_rd, acc_wr, sel_ok;
  logic [BUS_W-1:0]  sel_b;
  logic [SLOT_W:0]   wr_low;
  logic              wr_slot_ok;
  logic              plug_ok, unplug_ok;
  logic [SLOTS-1:0]  plug_hot, unplug_hot, ej_hot;
  logic              wr_ej, ej_fire, rd_clear_up;
  logic [BUS_W-1:0]  ej_bus_n;
  logic [SLOT_W-1:0] ej_slot_n;
  logic [DATA_W-1:0] rd_data;

  assign unused_addr_lo = req_addr[1:0];
  assign word       = req_addr[4:2];
  assign acc_rd     = req_valid && !req_write && !sweeping;
  assign acc_wr     = req_valid && req_write && !sweeping;
  assign sel_ok     = sel_q < 32'(NUM_BUS);
  assign sel_b      = sel_q[BUS_W-1:0];
  assign wr_low     = lowest_set(req_wdata);
  assign wr_slot_ok = !wr_low[SLOT_W];

  assign plug_ok    = plug_valid   && ({1'b0, plug_bus}   < (BUS_W+1)'(NUM_BUS));
  assign unplug_ok  = unplug_valid && ({1'b0, unplug_bus} < (BUS_W+1)'(NUM_BUS));
  assign plug_hot   = SLOTS'(1) << plug_slot;
  assign unplug_hot = SLOTS'(1) << unplug_slot;

  // eject source: sweep and firmware never coincide (writes ignored in sweep)
  assign wr_ej      = acc_wr && (word == WRD_EJECT) && sel_ok && wr_slot_ok;
  assign ej_fire    = wr_ej || sw_req;
  assign ej_bus_n   = sw_req ? sw_bus  : sel_b;
  assign ej_slot_n  = sw_req ? sw_slot : wr_low[SLOT_W-1:0];
  assign ej_hot     = ej_fire ? (SLOTS'(1) << ej_slot_n) : '0;
  assign rd_clear_up = acc_rd && (word == WRD_INSERT) && !legacy_mode && sel_ok;

  for (genvar k = 0; k < ENTRIES; k++) begin : g_idx
    assign idx_view[k] = idx_table[k*IDX_W +: IDX_W];
  end

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic             this_ej;
    logic [SLOTS-1:0] set_up_b, set_dn_b, clr_up_b, clr_dn_b;
    assign this_ej  = ej_fire && (ej_bus_n == BUS_W'(b));
    assign set_up_b = (plug_ok   && plug_bus   == BUS_W'(b)) ? plug_hot   : '0;
    assign set_dn_b = (unplug_ok && unplug_bus == BUS_W'(b)) ? unplug_hot : '0;
    assign clr_dn_b = this_ej ? ej_hot : '0;
    assign clr_up_b = clr_dn_b | ((rd_clear_up && sel_b == BUS_W'(b)) ? '1 : '0);

    hp_bus_status u_status (
      .clk        (clk),
      .rst        (rst),
      .set_up     (set_up_b),
      .set_dn     (set_dn_b),
      .clr_up     (clr_up_b),
      .clr_dn     (clr_dn_b),
      .load_rmv   (sw_done),
      .fixed_mask (fixed_mask[b*SLOTS +: SLOTS]),
      .up         (up_a[b]),
      .dn         (dn_a[b]),
      .rmv        (rmv_a[b])
    );
  end

  hp_sweep #(.NUM_BUS(NUM_BUS), .BUS_W(BUS_W)) u_sweep (
    .clk     (clk),
    .rst     (rst),
    .start   (warm_rst),
    .dn_bus  (dn_a),
    .active  (sweeping),
    .ej_req  (sw_req),
    .ej_bus  (sw_bus),
    .ej_slot (sw_slot),
    .done    (sw_done)
  );

  always_comb begin
    rd_data = '0;
    if (!sweeping && sel_ok) begin
      case (word)
        WRD_INSERT: rd_data = up_a[sel_b];
        WRD_REMOVE: rd_data = dn_a[sel_b];
        WRD_RMVBL:  rd_data = rmv_a[sel_b];
        WRD_SELECT: rd_data = sel_q;
        WRD_INDEX:  rd_data = DATA_W'(idx_q);
        default:    rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= 32'(DEFAULT_BUS);
      idx_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_q       <= '0;
      notify_q    <= 1'b0;
      ej_v_q      <= 1'b0;
      ej_b_q      <= '0;
      ej_s_q      <= '0;
    end else begin
      rsp_valid_q <= req_valid && !req_write;
      rsp_q       <= rd_data;
      notify_q    <= plug_ok || unplug_ok;
      ej_v_q      <= ej_fire;
      ej_b_q      <= ej_bus_n;
      ej_s_q      <= ej_slot_n;
      if (acc_wr) begin
        idx_q <= '0;
        if (word == WRD_SELECT)
          sel_q <= legacy_mode ? 32'(DEFAULT_BUS) : req_wdata;
        if (word == WRD_INDEX && sel_ok && wr_slot_ok)
          idx_q <= idx_view[{sel_b, wr_low[SLOT_W-1:0]}];
      end else if (acc_rd && word == WRD_INDEX) begin
        idx_q <= '0;
      end
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_q;
  assign notify      = notify_q;
  assign eject_valid = ej_v_q;
  assign eject_bus   = ej_b_q;
  assign eject_slot  = ej_s_q;

  assert_rsp_R12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  assert_no_rsp_R12: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid);

  assert_legacy_sel_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && word == WRD_SELECT && legacy_mode) |=> (sel_q == 32'(DEFAULT_BUS)));

  assert_eject_bus_R7: assert property (@(posedge clk) disable iff (rst)
    eject_valid |-> ({1'b0, eject_bus} < (BUS_W+1)'(NUM_BUS)));

  assert_read_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_clear_up && !plug_valid) |=> (up_a[sel_b] == '0));
endmodule

// File: tb/hp_status_bank_tb.sv
`timescale 1ns/100ps
module hp_status_bank_tb;
  localparam int NB = 4;
  localparam int IW = 14;
  localparam int BW = 2;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic warm_rst = 1'b0, legacy_mode = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic plug_valid = 1'b0, unplug_valid = 1'b0;
  logic [BW-1:0] plug_bus = '0, unplug_bus = '0;
  logic [4:0] plug_slot = '0, unplug_slot = '0;
  logic [NB*32-1:0] fixed_mask;
  logic [NB*32*IW-1:0] idx_table;
  logic notify, eject_valid;
  logic [BW-1:0] eject_bus;
  logic [4:0] eject_slot;

  int checks = 0;
  int errors = 0;
  int ej_cnt = 0;
  logic [1:0] ej_b_log [8];
  logic [4:0] ej_s_log [8];
  string tags [NV];

  always #2.5 clk = ~clk;

  hp_status_bank #(.NUM_BUS(NB), .IDX_W(IW), .DEFAULT_BUS(0)) u_dut (
    .clk(clk), .rst(rst), .warm_rst(warm_rst), .legacy_mode(legacy_mode),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .plug_valid(plug_valid), .plug_bus(plug_bus), .plug_slot(plug_slot),
    .unplug_valid(unplug_valid), .unplug_bus(unplug_bus), .unplug_slot(unplug_slot),
    .fixed_mask(fixed_mask), .idx_table(idx_table), .notify(notify),
    .eject_valid(eject_valid), .eject_bus(eject_bus), .eject_slot(eject_slot)
  );

  // {write, addr, wdata, expected read}
  localparam logic [69:0] VEC [NV] = '{
    {1'b0, 5'h04, 32'h0, 32'h0000_0020},
    {1'b0, 5'h00, 32'h0, 32'h0000_0220},
    {1'b0, 5'h00, 32'h0, 32'h0000_0000},
    {1'b0, 5'h08, 32'h0, 32'h0000_0000},
    {1'b1, 5'h14, 32'h0000_0A00, 32'h0},
    {1'b0, 5'h14, 32'h0, 32'h0000_000A},
    {1'b0, 5'h14, 32'h0, 32'h0000_0000},
    {1'b1, 5'h10, 32'h1, 32'h0},
    {1'b0, 5'h10, 32'h0, 32'h0000_0001},
    {1'b0, 5'h0C, 32'h0, 32'h7FFF_FFFF},
    {1'b1, 5'h14, 32'h8, 32'h0},
    {1'b0, 5'h14, 32'h0, 32'h0000_0068},
    {1'b1, 5'h14, 32'h8, 32'h0},
    {1'b1, 5'h10, 32'h0, 32'h0},
    {1'b0, 5'h14, 32'h0, 32'h0000_0000},
    {1'b1, 5'h10, 32'h7, 32'h0},
    {1'b0, 5'h10, 32'h0, 32'h0000_0000},
    {1'b0, 5'h0C, 32'h0, 32'h0000_0000},
    {1'b0, 5'h04, 32'h0, 32'h0000_0000},
    {1'b1, 5'h08, 32'h20, 32'h0},
    {1'b1, 5'h10, 32'h0, 32'h0},
    {1'b0, 5'h04, 32'h0, 32'h0000_0020},
    {1'b0, 5'h1C, 32'h0, 32'h0000_0000},
    {1'b0, 5'h06, 32'h0, 32'h0000_0020}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    chk("R12 rsp_valid", {31'b0, rsp_valid}, 32'h1);
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    do_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic ev(input logic is_plug, input logic [BW-1:0] b, input logic [4:0] s);
    @(negedge clk);
    if (is_plug) begin plug_valid = 1'b1; plug_bus = b; plug_slot = s; end
    else begin unplug_valid = 1'b1; unplug_bus = b; unplug_slot = s; end
    @(negedge clk);
    plug_valid = 1'b0; unplug_valid = 1'b0;
    chk("R2 notify pulse", {31'b0, notify}, 32'h1);
    @(negedge clk);
    chk("R2 notify single cycle", {31'b0, notify}, 32'h0);
  endtask

  always @(negedge clk) begin
    if (!rst && eject_valid) begin
      if (ej_cnt < 8) begin
        ej_b_log[ej_cnt] = eject_bus;
        ej_s_log[ej_cnt] = eject_slot;
      end
      ej_cnt++;
    end
  end

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    fixed_mask = '0;
    fixed_mask[31:0]  = 32'h0000_0003;
    fixed_mask[63:32] = 32'h8000_0000;
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 32; s++)
        idx_table[(b*32+s)*IW +: IW] = IW'(b*100 + s + 1);
    tags = '{"R4","R3","R3","R4","R8","R8","R8","R6","R6","R4","R8","R8",
             "R9","R9","R9","R7","R7","R7","R7","R7","R6","R7","R12","R12"};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R1 notify", {31'b0, notify}, 32'h0);
    chk("R1 eject_valid", {31'b0, eject_valid}, 32'h0);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    rd_chk("R1 select", 5'h10, 32'h0);
    rd_chk("R1 removable", 5'h0C, 32'hFFFF_FFFC);
    rd_chk("R1 inserted", 5'h00, 32'h0);
    rd_chk("R1 removal", 5'h04, 32'h0);

    ev(1'b1, 2'd0, 5'd5);
    ev(1'b1, 2'd0, 5'd9);
    ev(1'b0, 2'd0, 5'd5);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][69]) begin
        do_wr(VEC[i][68:64], VEC[i][63:32]);
      end else begin
        do_rd(VEC[i][68:64], d);
        chk($sformatf("%s table %0d", tags[i], i), d, VEC[i][31:0]);
      end
    end

    // R5 eject of lowest set bit
    ev(1'b1, 2'd0, 5'd5);
    do_wr(5'h08, 32'h0000_0060);
    chk("R5 eject strobe", {31'b0, eject_valid}, 32'h1);
    chk("R5 eject bus", {30'b0, eject_bus}, 32'h0);
    chk("R5 eject slot", {27'b0, eject_slot}, 32'd5);
    @(negedge clk);
    chk("R5 eject one cycle", {31'b0, eject_valid}, 32'h0);
    rd_chk("R5 removal cleared", 5'h04, 32'h0);
    rd_chk("R5 inserted cleared", 5'h00, 32'h0);
    do_wr(5'h08, 32'h0);
    chk("R5 zero data no strobe", {31'b0, eject_valid}, 32'h0);

    // R10 set wins over read clear
    @(negedge clk);
    plug_valid = 1'b1; plug_bus = 2'd0; plug_slot = 5'd7;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 5'h00;
    @(negedge clk);
    plug_valid = 1'b0; req_valid = 1'b0;
    chk("R10 read before set", rsp_rdata, 32'h0);
    rd_chk("R10 set survived clear", 5'h00, 32'h0000_0080);

    // R3 / R6 legacy mode
    legacy_mode = 1'b1;
    ev(1'b1, 2'd0, 5'd2);
    rd_chk("R3 legacy first read", 5'h00, 32'h0000_0004);
    rd_chk("R3 legacy read keeps", 5'h00, 32'h0000_0004);
    do_wr(5'h10, 32'h3);
    rd_chk("R6 legacy select default", 5'h10, 32'h0);
    legacy_mode = 1'b0;
    rd_chk("R3 clear after legacy", 5'h00, 32'h0000_0004);
    rd_chk("R3 cleared", 5'h00, 32'h0);

    // R11 warm sweep
    ev(1'b0, 2'd1, 5'd10);
    ev(1'b0, 2'd1, 5'd3);
    ev(1'b0, 2'd2, 5'd0);
    do_wr(5'h10, 32'h1);
    fixed_mask[95:64] = 32'h0000_00F0;
    ej_cnt = 0;
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
    do_rd(5'h04, d);
    chk("R11 read during sweep", d, 32'h0);
    repeat (15) @(negedge clk);
    chk("R11 eject count", ej_cnt, 32'd3);
    chk("R11 first bus", {30'b0, ej_b_log[0]}, 32'd1);
    chk("R11 first slot", {27'b0, ej_s_log[0]}, 32'd3);
    chk("R11 second slot", {27'b0, ej_s_log[1]}, 32'd10);
    chk("R11 third bus", {30'b0, ej_b_log[2]}, 32'd2);
    chk("R11 third slot", {27'b0, ej_s_log[2]}, 32'd0);
    rd_chk("R11 bus1 removal empty", 5'h04, 32'h0);
    rd_chk("R11 bus1 removable", 5'h0C, 32'h7FFF_FFFF);
    do_wr(5'h10, 32'h2);
    rd_chk("R11 bus2 removable reloaded", 5'h0C, 32'hFFFF_FF0F);
    rd_chk("R11 bus2 removal empty", 5'h04, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule